// File: doc/BRIEF.md
# Serial-Commanded Sixteen-Way Switch Selector

This block receives channel commands over a slave SPI link and drives the enable lines of a sixteen-way analog switch matrix. The SPI master shifts an 8-bit command into the block while the active-low select is held low. When the select returns high, the frame closes. The block then takes the lowest four bits of its shift register as the new channel. Any change of channel runs through a timed break-before-make sequence. Every switch enable is dropped for a fixed number of system clocks before the enable of the new channel rises. This way two inputs are never shorted together.

All serial pins are sampled by the system clock through two-flop synchronizers, and their edges are detected in that domain. The SCLK high and low phases must each last at least three system clocks. The shift register also drives MISO, so several devices can be chained on one select line. A global output-enable is held low during reset, which lets the switch matrix float, and it rises once reset is released.

The sequencer has three states. `ST_HOLD` drives the one-hot enable of the current channel. `ST_BREAK` drives all enables low and counts system clocks. `ST_MAKE` is the final all-open cycle, in which the pending channel is loaded. The transitions are:
- T_START (`ST_HOLD` to `ST_BREAK`): taken when the pending channel differs from the current one.
- T_OPENED (`ST_BREAK` to `ST_MAKE`): taken when the break count reaches `BREAK_CYCLES-2`.
- T_CLOSE (`ST_MAKE` to `ST_HOLD`): always taken after one cycle.

`BREAK_CYCLES` must be at least 2.

Top module: `spi_switch_select`

## Requirements
- R1: While `rst_n` is low, `out_en` is 0 and `sw_en` is 16'h0001 (channel 0). The shift register is cleared to 8'h00, so the next frame returns 8'h00 on MISO.
- R2: In the first cycle after `rst_n` is released, `out_en` is 1 and `sw_en` is 16'h0001.
- R3: The register is 8 bits. It shifts left MSB first, taking MOSI on each rising SCLK while `ss_n` is low. SCLK edges while `ss_n` is high leave the register unchanged.
- R4: After a frame, `sw_en` has exactly bit n set, where n is register bits [3:0]. Bits [7:4] have no effect: both 8'h09 and 8'hF9 select bit 9.
- R5: `sw_en` does not change to a new channel while a frame is open. The new channel is taken only when `ss_n` rises.
- R6: On a channel change, `sw_en` is all zeros for exactly `BREAK_CYCLES` system clocks (default 8) between the old enable and the new one. Two enable bits are never set at once.
- R7: A commit whose low nibble equals the current channel causes no break, and `sw_en` stays unchanged. This includes a frame with no SCLK edges.
- R8: MISO presents register bit 7 before the first SCLK and updates on each falling SCLK. Sampled before each rising edge of an 8-bit frame, it returns the previous register contents, MSB first.
- R9: A frame closed after fewer than 8 SCLK edges commits the low nibble of the partially shifted register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data toward the master or the next device in a chain |
| sw_en | output | 16 | One-hot switch enables, all zero during a break |
| out_en | output | 1 | Global switch-matrix output enable |

## Verification
Full 8-bit frames with random bytes test decoding under noisy upper nibbles. Each one's MISO stream is compared with the previous byte, which shows that the daisy-chain path holds the whole register and not only the channel bits. Frames that repeat the current channel, or that carry no bits, separate the real break-before-make path from needless breaks. Random short frames separate a partially shifted commit from a fixed 8-bit decode. SCLK toggled with the select high, and a reset in the middle of a run, show through the next frame's MISO stream that the register ignores clocks outside a frame and is cleared by reset.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_BREAK = 2'd1,
        ST_MAKE  = 2'd2
    } bbm_state_t;

endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0] chain [W];

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[b] <= {STAGES{RST_VAL[b]}};
            end else begin
                chain[b] <= {chain[b][STAGES-2:0], d[b]};
            end
        end
        assign q[b] = chain[b][STAGES-1];
    end

endmodule

// File: rtl/sws_shift.sv
module sws_shift #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             mosi_s,
    input  logic             ss_s,
    output logic [CMD_W-1:0] cmd_q,
    output logic             miso,
    output logic             sclk_rise,
    output logic             commit
);

    localparam int MSB = CMD_W - 1;

    logic sclk_d;
    logic ss_d;
    logic sclk_fall;
    logic miso_q;

    // edge detection in the system clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            ss_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            ss_d   <= ss_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign commit    = ss_s & ~ss_d;

    // command register: shifts only inside a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (sclk_rise && !ss_s) begin
            cmd_q <= {cmd_q[MSB-1:0], mosi_s};
        end
    end

    // serial output: top bit shown between frames, advanced on falling SCLK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_q <= 1'b0;
        end else if (ss_s || sclk_fall) begin
            miso_q <= cmd_q[MSB];
        end
    end

    assign miso = miso_q;

endmodule

// File: rtl/sws_bbm.sv
module sws_bbm
    import sws_pkg::*;
#(
    parameter int SEL_W        = 4,
    parameter int BREAK_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [SEL_W-1:0]     sel_in,
    output logic [SEL_W-1:0]     pend_sel,
    output logic [(1<<SEL_W)-1:0] sw_en,
    output logic                 out_en
);

    localparam int N_SW  = 1 << SEL_W;
    localparam int CNT_W = $clog2(BREAK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BREAK_CYCLES - 2);

    bbm_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] cur_q;
    logic [SEL_W-1:0] pend_q;
    logic             oe_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (pend_q != cur_q)   state_d = ST_BREAK; // T_START
            ST_BREAK: if (cnt_q == CNT_LAST) state_d = ST_MAKE;  // T_OPENED
            ST_MAKE:                          state_d = ST_HOLD;  // T_CLOSE
            default:                          state_d = ST_HOLD;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cur_q  <= '0;
            pend_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q <= 1'b1;
            if (commit) begin
                pend_q <= sel_in;
            end
            unique case (state_q)
                ST_HOLD:  cnt_q <= '0;
                ST_BREAK: cnt_q <= cnt_q + 1'b1;
                ST_MAKE:  cur_q <= pend_q;
                default:  cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sw_en  = '0;
        out_en = oe_q;
        unique case (state_q)
            ST_HOLD:  sw_en = N_SW'(1) << cur_q;
            ST_BREAK: sw_en = '0;
            ST_MAKE:  sw_en = '0;
            default:  sw_en = '0;
        endcase
    end

    assign pend_sel = pend_q;

endmodule

// File: rtl/spi_switch_select.sv
module spi_switch_select #(
    parameter int CMD_W        = 8,
    parameter int SEL_W        = 4,
    parameter int BREAK_CYCLES = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  mosi,
    input  logic                  ss_n,
    output logic                  miso,
    output logic [(1<<SEL_W)-1:0] sw_en,
    output logic                  out_en
);

    logic [2:0]       pins_s;
    logic             ss_sync;
    logic             sclk_sync;
    logic             mosi_sync;
    logic [CMD_W-1:0] cmd_q;
    logic             sclk_rise;
    logic             commit;
    logic [SEL_W-1:0] pend_sel;

    // idle levels: select high, clock low, data low
    sws_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n, sclk, mosi}),
        .q     (pins_s)
    );

    assign ss_sync   = pins_s[2];
    assign sclk_sync = pins_s[1];
    assign mosi_sync = pins_s[0];

    sws_shift #(
        .CMD_W (CMD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_sync),
        .mosi_s    (mosi_sync),
        .ss_s      (ss_sync),
        .cmd_q     (cmd_q),
        .miso      (miso),
        .sclk_rise (sclk_rise),
        .commit    (commit)
    );

    sws_bbm #(
        .SEL_W        (SEL_W),
        .BREAK_CYCLES (BREAK_CYCLES)
    ) u_bbm (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .sel_in   (cmd_q[SEL_W-1:0]),
        .pend_sel (pend_sel),
        .sw_en    (sw_en),
        .out_en   (out_en)
    );

endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
    parameter int CMD_W        = 8,
    parameter int SEL_W        = 4,
    parameter int BREAK_CYCLES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [(1<<SEL_W)-1:0] sw_en,
    input logic                  out_en,
    input logic                  ss_sync,
    input logic                  mosi_sync,
    input logic                  sclk_rise,
    input logic [CMD_W-1:0]      cmd_q,
    input logic [SEL_W-1:0]      pend_sel
);

    logic [7:0] zrun;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun <= '0;
        end else if (sw_en != '0) begin
            zrun <= '0;
        end else if (zrun != 8'hFF) begin
            zrun <= zrun + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_state_r1: assert (!out_en && sw_en == {{((1<<SEL_W)-1){1'b0}}, 1'b1})
                else $error("reset state wrong");
        end
    end

    p_oe_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> out_en);

    p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !ss_sync) |=> (cmd_q[0] == $past(mosi_sync)));

    p_ignore_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ss_sync |=> $stable(cmd_q));

    p_frame_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_sync && !$past(ss_sync)) |-> $stable(pend_sel));

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_en));

    p_no_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(sw_en)) && (|sw_en)) |-> (sw_en == $past(sw_en)));

    p_break_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sw_en) && zrun != 8'd0) |-> (zrun == 8'(BREAK_CYCLES)));

endmodule

bind spi_switch_select sws_checker #(
    .CMD_W        (CMD_W),
    .SEL_W        (SEL_W),
    .BREAK_CYCLES (BREAK_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_en     (sw_en),
    .out_en    (out_en),
    .ss_sync   (ss_sync),
    .mosi_sync (mosi_sync),
    .sclk_rise (sclk_rise),
    .cmd_q     (cmd_q),
    .pend_sel  (pend_sel)
);

// File: tb/test_spi_switch_select.sv
`timescale 1ns/1ps
module test_spi_switch_select;

    localparam int BRK = 8;
    localparam int H   = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sclk;
    logic        mosi;
    logic        ss_n;
    logic        miso;
    logic [15:0] sw_en;
    logic        out_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_sr;
    int         m_ch;

    int run     = 0;
    int runs    = 0;
    int last_run = 0;
    int twohot  = 0;

    always #2 clk = ~clk;

    spi_switch_select #(.BREAK_CYCLES(BRK)) i_spi_switch_select (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (sclk),
        .mosi   (mosi),
        .ss_n   (ss_n),
        .miso   (miso),
        .sw_en  (sw_en),
        .out_en (out_en)
    );

    function automatic logic [15:0] onehot(input int ch);
        return 16'(1) << ch;
    endfunction

    // zero-run monitor for break-before-make
    always @(negedge clk) begin
        if (rst_n !== 1'b1) begin
            run = 0;
        end else begin
            if (sw_en == 16'h0) begin
                run++;
            end else begin
                if (run > 0) begin
                    last_run = run;
                    runs++;
                end
                run = 0;
            end
            if ($countones(sw_en) > 1) twohot++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] d, input int n, input string miso_tag);
        logic [7:0] old;
        logic [7:0] got;
        int         r0;
        int         prev_ch;
        int         new_ch;
        old     = m_sr;
        got     = '0;
        r0      = runs;
        prev_ch = m_ch;
        ss_n    = 1'b0;
        wait_n(H);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = d[i];
            wait_n(H);
            got  = {got[6:0], miso};
            sclk = 1'b1;
            wait_n(H);
            sclk = 1'b0;
            m_sr = {m_sr[6:0], d[i]};
        end
        wait_n(H);
        // R5: no change while the frame is still open
        check(sw_en == onehot(prev_ch), "R5", sw_en, onehot(prev_ch));
        if (n == 8) check(got == old, miso_tag, got, old);
        ss_n = 1'b1;
        wait_n(BRK + 12);
        new_ch = int'(m_sr[3:0]);
        check(sw_en == onehot(new_ch) && out_en, (n < 8) ? "R9" : "R4",
              sw_en, onehot(new_ch));
        if (new_ch != prev_ch) begin
            check(runs == r0 + 1 && last_run == BRK, "R6", last_run, BRK);
        end else begin
            check(runs == r0, "R7", runs - r0, 0);
        end
        m_ch = new_ch;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        sclk  = 1'b0;
        mosi  = 1'b0;
        ss_n  = 1'b1;
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        m_sr = 8'h00;
        m_ch = 0;
        wait_n(5);
        check(out_en == 1'b0, "R1", out_en, 0);
        check(sw_en == 16'h0001, "R1", sw_en, 16'h0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_en == 1'b1, "R2", out_en, 1);
        check(sw_en == 16'h0001, "R2", sw_en, 16'h0001);
        wait_n(4);

        // directed cases
        frame(8'h09, 8, "R8");          // R4: selects 9, MISO returns 0x00
        frame(8'hF9, 8, "R8");          // R4/R7: upper nibble ignored, same channel
        frame(8'h3C, 8, "R8");
        frame(8'h00, 0, "R8");          // R7: empty frame, no break
        frame(8'h05, 3, "R8");          // R9: partial frame
        frame(8'hA0, 8, "R8");          // channel 0

        // R3: SCLK toggles while select is high must not shift
        mosi = 1'b1;
        for (int k = 0; k < 4; k++) begin
            sclk = 1'b1;
            wait_n(H);
            sclk = 1'b0;
            wait_n(H);
        end
        frame(8'h67, 8, "R3");

        // R1: reset mid-run clears channel and register
        rst_n = 1'b0;
        wait_n(2);
        check(out_en == 1'b0, "R1", out_en, 0);
        check(sw_en == 16'h0001, "R1", sw_en, 16'h0001);
        m_sr = 8'h00;
        m_ch = 0;
        rst_n = 1'b1;
        wait_n(2);
        check(out_en == 1'b1, "R2", out_en, 1);
        frame(8'hA5, 8, "R1");

        // random frames
        for (int it = 0; it < 120; it++) begin
            logic [7:0] d;
            int         n;
            d = 8'($urandom);
            n = ($urandom % 6 == 0) ? int'($urandom % 8) : 8;
            frame(d, n, "R8");
        end

        check(twohot == 0, "R6", twohot, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule